// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This unit watches three external input pins and turns a chosen signal transition on each pin into an interrupt request. Each channel can be set to ignore its pin or to react to rising, falling or both transitions. A detected transition always latches the channel's pending flag. The request line toward the processor is driven only while the flag is latched and the channel is enabled. Software removes a pending flag by writing zero to it. Writing one to the flag leaves it as it is, so the same write that enables a channel can also discard a stale flag.

A shared level register holds a 2-bit priority level for each channel, and the unit drives those levels out next to the request lines. The unit also drives the vector address of the most urgent active request. Each channel's vector address is fixed. A wake output combines all active requests without passing through a register, so it can release the device from stop mode while the processor clock is halted.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every channel has mode 00, enable 0 and flag 0, and the level register is 0. `irq`, `wake`, `irq_level` and `vec_addr` are all zero.
- R2: The edge mode field (register bits [1:0]) selects the transition: 00 ignores the pin, 01 detects a rising edge, 10 a falling edge and 11 both edges. Each pin passes through a two-flop synchronizer, so a matching transition sets the flag within three clock edges.
- R3: A matching transition sets the channel flag even while the enable bit is 0. In that case the channel's `irq` bit stays 0.
- R4: `irq[i]` is 1 exactly when channel i has both its flag and its enable bit set.
- R5: A write that carries 0 in the flag bit (bit 3) clears the flag. A write that carries 1 in that bit leaves the flag unchanged.
- R6: A write that sets the enable bit while the flag is already 1 and bit 3 is 1 raises `irq` on the next cycle. A write that sets enable and clears the flag in the same access keeps `irq` low.
- R7: When a detected transition and a flag-clearing write hit the same clock edge, the flag ends set.
- R8: The level register holds channel 0's level in bits [1:0], channel 1's in [3:2] and channel 2's in [5:4]. `irq_level` presents these bits, and they change only on a write to the level register.
- R9: `vec_addr` is the vector of the active request with the numerically smallest level, with ties going to the lower channel number. Channel 0's vector is 16'hFFFA, channel 1's is 16'hFFF8 and channel 2's is 16'hFFF6. `vec_addr` is 0 when no request is active.
- R10: `wake` is 1 whenever any `irq` bit is 1, without a register stage.
- R11: Channel i's register is at address i (0 to 2) and the level register is at address 3. A channel register reads back as {4'b0, flag, enable, mode}, and the level register as {2'b0, levels}. Written upper bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 3 | Asynchronous external interrupt pins, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq | output | 3 | Per-channel interrupt request lines |
| irq_level | output | 6 | Per-channel 2-bit priority levels |
| vec_addr | output | 16 | Vector address of the most urgent active request, or 0 |
| wake | output | 1 | Stop-mode release request |

## Verification
A flag stuck at 1 shows up in two ways. `irq` and `wake` rise on the very cycle after the channel is enabled, and a register read returns bit 3 set. A flag that cannot be set leaves `irq` low three edges after a matching transition, where it should have risen. A corrupted synchronizer or previous-value register fires a transition from the wrong edge type, or reports it one cycle late. A corrupted level register changes `vec_addr` on the next read, because the winner changes among several active requests.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int MODE_LSB = 0;
    localparam int MODE_W   = 2;
    localparam int EN_BIT   = 2;
    localparam int FLAG_BIT = 3;
    localparam int CTL_W    = FLAG_BIT + 1;

    localparam int LVL_W = 2;
    localparam int VEC_W = 16;

    localparam logic [VEC_W-1:0] VEC_FIRST = 16'hFFFA;
    localparam logic [VEC_W-1:0] VEC_STEP  = 16'd2;

    typedef struct packed {
        edge_mode_e mode;
        logic       en;
        logic       flag;
    } chan_state_t;

    function automatic logic [VEC_W-1:0] chan_vector(input int unsigned ch);
        return VEC_FIRST - VEC_STEP * VEC_W'(ch);
    endfunction

endpackage

// File: rtl/eirq_edge_det.sv
`timescale 1ns/1ps
module eirq_edge_det
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       hit
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic level_now;
    logic rise;
    logic fall;

    always_comb begin
        st_d      = st_q;
        level_now = st_q.sync[SYNC_STAGES-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev = level_now;
        rise      = level_now & ~st_q.prev;
        fall      = ~level_now & st_q.prev;
        hit       = 1'b0;
        unique case (mode)
            EDGE_OFF:  hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/eirq_chan.sv
`timescale 1ns/1ps
module eirq_chan
    import ext_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              hit,
    output edge_mode_e        mode,
    output logic              en,
    output logic              flag,
    output logic              req,
    output logic [DATA_W-1:0] rdata
);

    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mode = edge_mode_e'(wdata[MODE_LSB +: MODE_W]);
            s_d.en   = wdata[EN_BIT];
            s_d.flag = s_q.flag & wdata[FLAG_BIT];
        end
        if (hit) begin
            s_d.flag = 1'b1;
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[MODE_LSB +: MODE_W] = s_q.mode;
        rdata[EN_BIT]             = s_q.en;
        rdata[FLAG_BIT]           = s_q.flag;
    end

    assign mode = s_q.mode;
    assign en   = s_q.en;
    assign flag = s_q.flag;
    assign req  = s_q.flag & s_q.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: EDGE_OFF, en: 1'b0, flag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/eirq_prio_sel.sv
`timescale 1ns/1ps
module eirq_prio_sel
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0]       req,
    input  logic [NUM_CH*LVL_W-1:0] lvl,
    output logic [VEC_W-1:0]        vec
);

    logic             found;
    logic [LVL_W-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        vec   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!found || (lvl[i*LVL_W +: LVL_W] < best))) begin
                found = 1'b1;
                best  = lvl[i*LVL_W +: LVL_W];
                vec   = chan_vector(i);
            end
        end
    end

endmodule

// File: rtl/ext_irq_unit.sv
`timescale 1ns/1ps
module ext_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ext_pin,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        irq,
    output logic [NUM_CH*LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]         vec_addr,
    output logic                     wake
);

    localparam int LVL_REG_W = NUM_CH * LVL_W;
    localparam logic [ADDR_W-1:0] LVL_ADDR = ADDR_W'(NUM_CH);

    typedef struct packed {
        logic [LVL_REG_W-1:0] lvl;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [NUM_CH-1:0] edge_hit;
    logic [NUM_CH-1:0] flag_vec;
    logic [NUM_CH-1:0] en_vec;
    logic [NUM_CH-1:0] req_vec;
    logic [DATA_W-1:0] chan_rdata [NUM_CH];
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:LVL_REG_W];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        edge_mode_e mode_w;
        logic       wr_sel;

        assign wr_sel = bus_wr && (bus_addr == ADDR_W'(ch));

        eirq_edge_det #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_pin[ch]),
            .mode (mode_w),
            .hit  (edge_hit[ch])
        );

        eirq_chan #(
            .DATA_W(DATA_W)
        ) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr_sel),
            .wdata(bus_wdata[CTL_W-1:0]),
            .hit  (edge_hit[ch]),
            .mode (mode_w),
            .en   (en_vec[ch]),
            .flag (flag_vec[ch]),
            .req  (req_vec[ch]),
            .rdata(chan_rdata[ch])
        );
    end

    always_comb begin
        t_d = t_q;
        if (bus_wr && (bus_addr == LVL_ADDR)) begin
            t_d.lvl = bus_wdata[LVL_REG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata = chan_rdata[i];
            end
        end
        if (bus_addr == LVL_ADDR) begin
            bus_rdata[LVL_REG_W-1:0] = t_q.lvl;
        end
    end

    eirq_prio_sel #(
        .NUM_CH(NUM_CH)
    ) u_prio (
        .req(req_vec),
        .lvl(t_q.lvl),
        .vec(vec_addr)
    );

    assign irq       = req_vec;
    assign irq_level = t_q.lvl;
    assign wake      = |req_vec;

endmodule

// File: rtl/eirq_chk.sv
`timescale 1ns/1ps
module eirq_chk
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     wr_en_bit,
    input logic                     wr_flag_bit,
    input logic [NUM_CH-1:0]        edge_hit,
    input logic [NUM_CH-1:0]        flag_vec,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH*LVL_W-1:0]  irq_level,
    input logic [VEC_W-1:0]         vec_addr,
    input logic                     wake
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && irq_level == '0 && vec_addr == '0 && !wake));

    // R7
    edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((flag_vec & $past(edge_hit)) == $past(edge_hit)));

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(NUM_CH)) |=> $stable(irq_level));

    // R9
    vec_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (vec_addr != '0));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == '0) |-> (vec_addr == '0));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R5
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(ch) && !wr_flag_bit && !edge_hit[ch])
            |=> !flag_vec[ch]);

        // R6
        enable_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(ch) && wr_en_bit && wr_flag_bit && flag_vec[ch])
            |=> irq[ch]);
    end

endmodule

bind ext_irq_unit eirq_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_en_bit  (bus_wdata[ext_irq_pkg::EN_BIT]),
    .wr_flag_bit(bus_wdata[ext_irq_pkg::FLAG_BIT]),
    .edge_hit   (edge_hit),
    .flag_vec   (flag_vec),
    .irq        (irq),
    .irq_level  (irq_level),
    .vec_addr   (vec_addr),
    .wake       (wake)
);

// File: tb/sim_ext_irq_unit.sv
`timescale 1ns/1ps
module sim_ext_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pins = 3'b000;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic [2:0]  irq;
    logic [5:0]  irq_level;
    logic [15:0] vec_addr;
    logic        wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ext_irq_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (pins),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq),
        .irq_level(irq_level),
        .vec_addr (vec_addr),
        .wake     (wake)
    );

    // {ch[1:0], mode[1:0], start_pin, end_pin, expected_flag}
    localparam logic [6:0] TBL [12] = '{
        7'b00_01_0_1_1, 7'b00_01_1_0_0, 7'b00_10_1_0_1, 7'b00_10_0_1_0,
        7'b01_11_0_1_1, 7'b01_11_1_0_1, 7'b01_00_0_1_0, 7'b01_00_1_0_0,
        7'b10_01_0_1_1, 7'b10_10_0_1_0, 7'b10_11_1_0_1, 7'b10_00_0_1_0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL all requirements: watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        cycles(5);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        check("R1 irq", 16'(irq), 16'h0);
        check("R1 wake", 16'(wake), 16'h0);
        check("R1 vec_addr", vec_addr, 16'h0);
        check("R1 irq_level", 16'(irq_level), 16'h0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 R11 register reads zero", 16'(d), 16'h0);
        end

        // R2 R3 edge mode table, all channels disabled
        for (int t = 0; t < 12; t++) begin
            logic [1:0] ch;
            logic [1:0] md;
            ch = TBL[t][6:5];
            md = TBL[t][4:3];
            wr(ch, {6'b0, md});
            pins[ch] = TBL[t][2];
            cycles(6);
            wr(ch, {6'b0, md});
            @(negedge clk);
            pins[ch] = TBL[t][1];
            cycles(5);
            rd(ch, d);
            check("R2 flag after edge", 16'(d[3]), 16'(TBL[t][0]));
            check("R3 irq stays low while disabled", 16'(irq[ch]), 16'h0);
        end
        for (int c = 0; c < 3; c++) wr(2'(c), 8'h00);
        pins = 3'b000;
        cycles(6);

        // R5 write-one keeps, write-zero clears
        wr(2'd1, 8'h01);
        @(negedge clk);
        pins[1] = 1'b1;
        cycles(5);
        rd(2'd1, d);
        check("R3 R11 flag set while disabled", 16'(d), 16'h09);
        check("R3 irq low", 16'(irq), 16'h0);
        wr(2'd1, 8'h09);
        rd(2'd1, d);
        check("R5 write one keeps flag", 16'(d), 16'h09);
        wr(2'd1, 8'h01);
        rd(2'd1, d);
        check("R5 write zero clears flag", 16'(d), 16'h01);

        // R6 enabling with a pending flag
        @(negedge clk);
        pins[1] = 1'b0;
        cycles(5);
        pins[1] = 1'b1;
        cycles(5);
        wr(2'd1, 8'h0D);
        check("R6 irq at once on enable", 16'(irq), 16'h2);
        check("R10 wake follows irq", 16'(wake), 16'h1);
        check("R9 vector channel 1", vec_addr, 16'hFFF8);
        wr(2'd1, 8'h05);
        check("R4 irq drops after clear", 16'(irq), 16'h0);
        check("R10 wake drops", 16'(wake), 16'h0);
        @(negedge clk);
        pins[1] = 1'b0;
        cycles(5);
        pins[1] = 1'b1;
        cycles(5);
        check("R4 edge while enabled raises irq", 16'(irq), 16'h2);
        wr(2'd1, 8'h09);
        check("R4 disable masks irq", 16'(irq), 16'h0);
        wr(2'd1, 8'h05);
        check("R6 enable with clear keeps irq low", 16'(irq), 16'h0);
        rd(2'd1, d);
        check("R6 R11 readback", 16'(d), 16'h05);

        // R7 edge and clear on the same edge
        wr(2'd2, 8'h01);
        @(negedge clk);
        pins[2] = 1'b1;
        @(negedge clk);
        wr(2'd2, 8'h01);
        rd(2'd2, d);
        check("R7 edge wins over clear", 16'(d), 16'h09);
        wr(2'd2, 8'h01);
        rd(2'd2, d);
        check("R5 later clear takes effect", 16'(d), 16'h01);

        // R8 level register
        wr(2'd3, 8'h27);
        check("R8 irq_level", 16'(irq_level), 16'h27);
        rd(2'd3, d);
        check("R8 R11 level readback", 16'(d), 16'h27);
        wr(2'd3, 8'hE7);
        rd(2'd3, d);
        check("R11 level upper bits discarded", 16'(d), 16'h27);

        // R9 vector arbitration
        for (int c = 0; c < 3; c++) wr(2'(c), 8'h07);
        @(negedge clk);
        pins = ~pins;
        cycles(5);
        check("R4 all channels pending", 16'(irq), 16'h7);
        check("R9 lowest level wins", vec_addr, 16'hFFF8);
        wr(2'd1, 8'h07);
        check("R9 next lowest level", vec_addr, 16'hFFF6);
        wr(2'd3, 8'h00);
        check("R9 tie goes to lower channel", vec_addr, 16'hFFFA);
        check("R10 wake with two pending", 16'(wake), 16'h1);
        wr(2'd0, 8'h07);
        check("R9 remaining channel 2", vec_addr, 16'hFFF6);
        wr(2'd2, 8'h07);
        check("R9 idle vector", vec_addr, 16'h0);
        check("R10 wake idle", 16'(wake), 16'h0);

        // R11 field layout
        wr(2'd0, 8'hF2);
        rd(2'd0, d);
        check("R11 upper bits read zero", 16'(d), 16'h02);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule